// File: doc/BRIEF.md
# Lane-Partitioned Saturating Vector Subtractor

This block subtracts one packed vector from another, lane by lane, and clamps every lane result that leaves the element range instead of letting it wrap. The lane width (8, 16, 32 or 64 bits) and the signed or unsigned reading of the lanes are both chosen per operation at run time. A half-width select limits an operation to the lower half of the vector. In that mode the upper half of the result is forced to zero.

An operation is issued by raising `start` for one cycle with the operands and mode inputs valid. The result appears on the next clock edge together with a one-cycle `done` pulse. A single sticky flag records that some active lane saturated in any operation since it was last cleared. It is cleared only by reset or by the synchronous `clr_sat` input. No carry, zero, negative or overflow flags are produced.

Top module: `sat_vec_sub`

## Requirements
- R1: Each lane of `result` equals the lane of `op_a` minus the same lane of `op_b` whenever the exact difference fits the element range. No borrow passes between lanes.
- R2: With `uns_sel`=0 (two's-complement lanes), a difference above the range gives the lane maximum (0x7F for 8 bits). A difference below the range gives the lane minimum (0x80 for 8 bits).
- R3: With `uns_sel`=1 (unsigned lanes), a negative difference gives 0. The same operands give different results in the two modes when a clamp occurs.
- R4: `size_sel` picks the lane width: 2'b00 gives 8 bits, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64. Lane k occupies bits [k*W +: W].
- R5: With `quad_sel`=0, only bits [63:0] are computed. `result[127:64]` is 0, and upper lanes never affect `sat_flag`.
- R6: `sat_flag` becomes 1 on the edge that registers an operation in which any active lane saturated. It stays 1 through later operations that do not saturate.
- R7: `sat_flag` is 0 after reset. `clr_sat` clears it on the next edge, unless an operation registered on that same edge saturates; in that case it ends at 1.
- R8: `result` and `done` change on the clock edge that samples `start`=1. `done` is high for exactly that one cycle, and `result` holds its value while `start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Issue strobe; operands and modes sampled when high |
| op_a | input | 128 | Minuend vector |
| op_b | input | 128 | Subtrahend vector |
| size_sel | input | 2 | Lane width code (00=8, 01=16, 10=32, 11=64) |
| uns_sel | input | 1 | 1 = unsigned lanes, 0 = signed lanes |
| quad_sel | input | 1 | 1 = full 128-bit vector, 0 = lower 64 bits only |
| clr_sat | input | 1 | Synchronous clear of the sticky saturation flag |
| result | output | 128 | Registered saturated difference |
| done | output | 1 | One-cycle pulse when `result` updates |
| sat_flag | output | 1 | Sticky cumulative saturation flag |

## Verification
The hardest cases to reach from the ports are the ones that depend on how saturation meets the half-width mode and the flag clear. One is a clear issued in the same cycle as a saturating operation. Another is a saturation that occurs only in an upper lane while half-width mode is selected. The stimulus sets up each one directly. It first drives the flag high, then issues `clr_sat` together with a `start` whose lane overflows. Separately, it clears the flag and issues a half-width operation whose only overflowing lanes sit in bits [127:64]. It checks that the flag stays low and that those result bits are zero.

// File: rtl/sat_vec_sub_pkg.sv
// Shared constants and types for the saturating vector subtractor.
// Assumes the vector width is a multiple of the widest lane (64 bits).
package sat_vec_sub_pkg;
    localparam int VEC_W     = 128;
    localparam int MIN_LANE  = 8;
    localparam int NUM_SIZES = 4;

    typedef enum logic [1:0] {
        ESZ_8  = 2'b00,
        ESZ_16 = 2'b01,
        ESZ_32 = 2'b10,
        ESZ_64 = 2'b11
    } elem_size_e;
endpackage

// File: rtl/vsub_lane.sv
// One saturating subtract lane of width W.
// Computes a-b at W+1 bits and clamps it to the signed or unsigned range.
// Assumes W >= 2. Purely combinational.
module vsub_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         uns,
    output logic [W-1:0] y,
    output logic         sat
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] diff;

    // Extended difference, then range check and clamp
    always_comb begin
        if (uns) begin
            diff = {1'b0, a} - {1'b0, b};
            sat  = diff[W];
            y    = sat ? '0 : diff[W-1:0];
        end else begin
            diff = {a[W-1], a} - {b[W-1], b};
            sat  = diff[W] ^ diff[W-1];
            y    = sat ? (diff[W] ? SMIN : SMAX) : diff[W-1:0];
        end
    end
endmodule

// File: rtl/vsub_bank.sv
// Splits the vector into lanes of LANE_W bits and subtracts each lane.
// In half mode (quad=0) the upper lanes are zeroed and their saturation is masked.
// Assumes VEC_W is a multiple of 2*LANE_W.
module vsub_bank #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic             uns,
    input  logic             quad,
    output logic [VEC_W-1:0] y,
    output logic             sat_any
);
    localparam int NLANES = VEC_W / LANE_W;
    localparam int HALF_W = VEC_W / 2;

    logic [NLANES-1:0] lane_sat;

    for (genvar k = 0; k < NLANES; k++) begin : g_lane
        localparam bit IN_LOW = (k * LANE_W) < HALF_W;
        logic [LANE_W-1:0] ly;
        logic              ls;
        logic              active;

        vsub_lane #(.W(LANE_W)) u_lane (
            .a   (a[k*LANE_W +: LANE_W]),
            .b   (b[k*LANE_W +: LANE_W]),
            .uns (uns),
            .y   (ly),
            .sat (ls)
        );

        // Lane is live in quad mode, or always when it sits in the low half
        assign active                  = quad | IN_LOW;
        assign y[k*LANE_W +: LANE_W]   = active ? ly : '0;
        assign lane_sat[k]             = active & ls;
    end

    assign sat_any = |lane_sat;
endmodule

// File: rtl/vsub_sat_accum.sv
// Sticky cumulative saturation flag.
// Synchronous active-low reset; clear loses to a same-cycle new saturation.
module vsub_sat_accum (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    output logic flag
);
    // Hold, clear, or set the sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= (flag & ~clr) | set;
    end
endmodule

// File: rtl/sat_vec_sub.sv
// Top level: builds one subtract bank per lane width and selects one by size code.
// Registers the result and raises done one cycle after start.
// Assumes inputs are stable around the sampling edge; no backpressure.
module sat_vec_sub
    import sat_vec_sub_pkg::*;
#(
    parameter int VEC_W = sat_vec_sub_pkg::VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VEC_W-1:0] op_a,
    input  logic [VEC_W-1:0] op_b,
    input  logic [1:0]       size_sel,
    input  logic             uns_sel,
    input  logic             quad_sel,
    input  logic             clr_sat,
    output logic [VEC_W-1:0] result,
    output logic             done,
    output logic             sat_flag
);
    logic [VEC_W-1:0] bank_y   [NUM_SIZES];
    logic [NUM_SIZES-1:0] bank_sat;
    logic [VEC_W-1:0] sel_y;
    logic             sel_sat;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        vsub_bank #(.VEC_W(VEC_W), .LANE_W(MIN_LANE << s)) u_bank (
            .a       (op_a),
            .b       (op_b),
            .uns     (uns_sel),
            .quad    (quad_sel),
            .y       (bank_y[s]),
            .sat_any (bank_sat[s])
        );
    end

    // Pick the bank matching the requested lane width
    always_comb begin
        case (elem_size_e'(size_sel))
            ESZ_8:   begin sel_y = bank_y[0]; sel_sat = bank_sat[0]; end
            ESZ_16:  begin sel_y = bank_y[1]; sel_sat = bank_sat[1]; end
            ESZ_32:  begin sel_y = bank_y[2]; sel_sat = bank_sat[2]; end
            default: begin sel_y = bank_y[3]; sel_sat = bank_sat[3]; end
        endcase
    end

    // Register the result on issue and pulse done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= start;
            if (start) result <= sel_y;
        end
    end

    vsub_sat_accum u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_sat),
        .set   (start & sel_sat),
        .flag  (sat_flag)
    );
endmodule

// File: rtl/sat_vec_sub_chk.sv
// Property checker for sat_vec_sub, bound to every instance.
module sat_vec_sub_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [VEC_W-1:0] op_a,
    input logic [VEC_W-1:0] op_b,
    input logic [1:0]       size_sel,
    input logic             uns_sel,
    input logic             quad_sel,
    input logic             clr_sat,
    input logic [VEC_W-1:0] result,
    input logic             done,
    input logic             sat_flag
);
    // R8
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));
    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !quad_sel) |=> (result[VEC_W-1:VEC_W/2] == '0));
    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !clr_sat) |=> sat_flag);
    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sat && !start) |=> !sat_flag);
    // R7
    reset_flag_chk: assert property (@(posedge clk)
        !rst_n |=> !sat_flag);
    // R3
    uns_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && uns_sel && size_sel == 2'b00 && op_a[7:0] < op_b[7:0])
        |=> (result[7:0] == 8'h00 && sat_flag));
endmodule

bind sat_vec_sub sat_vec_sub_chk #(.VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .size_sel(size_sel), .uns_sel(uns_sel), .quad_sel(quad_sel),
    .clr_sat(clr_sat), .result(result), .done(done), .sat_flag(sat_flag)
);

// File: tb/sat_vec_sub_test.sv
module sat_vec_sub_test;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [127:0] op_a, op_b;
    logic [1:0]   size_sel;
    logic         uns_sel, quad_sel, clr_sat;
    logic [127:0] result;
    logic         done, sat_flag;

    int total = 0;
    int bad   = 0;
    logic exp_flag = 1'b0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    sat_vec_sub uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .size_sel(size_sel), .uns_sel(uns_sel), .quad_sel(quad_sel),
        .clr_sat(clr_sat), .result(result), .done(done), .sat_flag(sat_flag)
    );

    // Behavioural model: lane-wise exact difference with clamping
    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [1:0] sz, input logic u, input logic q,
                                           output logic s);
        int w = 8 << sz;
        logic [127:0] out = '0;
        logic [63:0]  mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        s = 1'b0;
        for (int i = 0; i < 128 / w; i++) begin
            logic [127:0] ta = a >> (i * w);
            logic [127:0] tb = b >> (i * w);
            logic [63:0]  la = ta[63:0] & mask;
            logic [63:0]  lb = tb[63:0] & mask;
            logic signed [67:0] va = {4'b0, la};
            logic signed [67:0] vb = {4'b0, lb};
            logic signed [67:0] mx, mn, d;
            logic [63:0] lr;
            if (!u && la[w-1]) va = va | ~{4'b0, mask};
            if (!u && lb[w-1]) vb = vb | ~{4'b0, mask};
            if (u) begin mx = {4'b0, mask}; mn = 0; end
            else begin mx = {4'b0, mask >> 1}; mn = -mx - 1; end
            d = va - vb;
            if (q || (i * w) < 64) begin
                if (d > mx) begin d = mx; s = 1'b1; end
                else if (d < mn) begin d = mn; s = 1'b1; end
                lr = d[63:0] & mask;
                out = out | ({64'b0, lr} << (i * w));
            end
        end
        return out;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation and check result and flag after the registering edge
    task automatic run_op(input string req, input logic [127:0] a, input logic [127:0] b,
                          input logic [1:0] sz, input logic u, input logic q, input logic clr);
        logic s;
        logic [127:0] exp;
        exp = model(a, b, sz, u, q, s);
        @(negedge clk);
        op_a = a; op_b = b; size_sel = sz; uns_sel = u; quad_sel = q;
        clr_sat = clr; start = 1'b1;
        @(negedge clk);
        start = 1'b0; clr_sat = 1'b0;
        exp_flag = (exp_flag & ~clr) | s;
        check({req, " result"}, result, exp);
        check({req, " flag"}, {127'b0, sat_flag}, {127'b0, exp_flag});
    endtask

    task automatic test_reset;
        check("R7 reset flag", {127'b0, sat_flag}, 128'b0);
        check("R8 reset done", {127'b0, done}, 128'b0);
    endtask

    task automatic test_in_range;
        run_op("R1 8b", {16{8'h35}}, {16{8'h12}}, 2'b00, 1'b0, 1'b1, 1'b0);
        run_op("R1 16b", {8{16'h1234}}, {8{16'h0034}}, 2'b01, 1'b1, 1'b1, 1'b0);
        run_op("R4 32b no cross borrow", {4{32'h0001_0000}}, {4{32'h0000_0001}}, 2'b10, 1'b1, 1'b1, 1'b0);
        run_op("R4 64b", {2{64'h0000_0001_0000_0000}}, {2{64'h0000_0000_FFFF_FFFF}}, 2'b11, 1'b0, 1'b1, 1'b0);
        check("R4 64b lane0", result[63:0], 128'd1);
        check("R6 no sat flag low", {127'b0, sat_flag}, 128'b0);
    endtask

    task automatic test_signed_clamp;
        run_op("R2 8b max", {16{8'h7F}}, {16{8'hFF}}, 2'b00, 1'b0, 1'b1, 1'b1);
        check("R2 8b max lane", result[7:0], 128'h7F);
        run_op("R2 16b min", {8{16'h8000}}, {8{16'h0001}}, 2'b01, 1'b0, 1'b1, 1'b1);
        check("R2 16b min lane", result[15:0], 128'h8000);
        run_op("R2 64b max", {2{64'h7FFF_FFFF_FFFF_FFFF}}, {2{64'h8000_0000_0000_0000}}, 2'b11, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic test_unsigned_clamp;
        run_op("R3 8b floor", {16{8'h10}}, {16{8'h20}}, 2'b00, 1'b1, 1'b1, 1'b1);
        check("R3 8b zero", result, 128'b0);
        run_op("R3 signed differs", {16{8'h10}}, {16{8'h20}}, 2'b00, 1'b0, 1'b1, 1'b1);
        check("R3 signed value", result[7:0], 128'hF0);
        run_op("R3 32b mix", {32'h5, 32'h1, 32'hFFFF_FFFF, 32'h0}, {32'h3, 32'h2, 32'h1, 32'h0},
               2'b10, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic test_half;
        run_op("R5 upper zero", {128{1'b1}}, {8{16'h0001}}, 2'b01, 1'b1, 1'b0, 1'b1);
        check("R5 upper bits", {64'b0, result[127:64]}, 128'b0);
        run_op("R5 upper sat masked", {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0009},
               {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002}, 2'b00, 1'b1, 1'b0, 1'b1);
        check("R5 flag stays low", {127'b0, sat_flag}, 128'b0);
    endtask

    task automatic test_sticky;
        run_op("R6 set", {16{8'h00}}, {16{8'h01}}, 2'b00, 1'b1, 1'b1, 1'b1);
        run_op("R6 hold", {16{8'h05}}, {16{8'h01}}, 2'b00, 1'b1, 1'b1, 1'b0);
        check("R6 still set", {127'b0, sat_flag}, 128'b1);
    endtask

    task automatic test_clear;
        @(negedge clk); clr_sat = 1'b1;
        @(negedge clk); clr_sat = 1'b0; exp_flag = 1'b0;
        check("R7 clear", {127'b0, sat_flag}, 128'b0);
        run_op("R6 reset for R7", {16{8'h00}}, {16{8'h01}}, 2'b00, 1'b1, 1'b1, 1'b0);
        run_op("R7 clear vs sat", {8{16'h8000}}, {8{16'h7FFF}}, 2'b01, 1'b0, 1'b1, 1'b1);
        check("R7 sat wins", {127'b0, sat_flag}, 128'b1);
    endtask

    task automatic test_timing;
        logic [127:0] held;
        run_op("R8 issue", {16{8'h44}}, {16{8'h11}}, 2'b00, 1'b1, 1'b1, 1'b0);
        check("R8 done high", {127'b0, done}, 128'b1);
        held = result;
        @(negedge clk);
        op_a = '0; op_b = {128{1'b1}};
        @(negedge clk);
        check("R8 done low", {127'b0, done}, 128'b0);
        check("R8 result held", result, held);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; op_a = '0; op_b = '0;
        size_sel = 2'b00; uns_sel = 1'b0; quad_sel = 1'b1; clr_sat = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_in_range();
        test_signed_clamp();
        test_unsigned_clamp();
        test_half();
        test_sticky();
        test_clear();
        test_timing();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule